// File: doc/BRIEF.md
# Asymmetric Simple Dual-Port RAM

This block is a synthesizable memory with one write-only port and one read-only port. The two ports can have different data widths. The write port's width and depth are parameters. A signed ratio exponent sets how much wider or narrower the read port is, and the read port's width and depth are derived from these so that both ports address the same total number of bits. Storage is split into lanes, each as wide as the narrower port. A wide access touches every lane at one row. A narrow access touches one lane, chosen by the low address bits.

Each port has an address-enable input that freezes its address register. While the enable is low, the port keeps using the last address it captured. The write port can mask its data in 8-bit groups. The read port registers its output. That register is gated by a read enable and cleared by a synchronous, active-high reset. A parameter chooses between one shared clock and separate write and read clocks. When a read and a write hit the same location in the same edge of the shared clock, the read returns the old contents.

Top module: `asym_sdp_ram`

## Requirements
- R1: The ratio exponent is an integer from -4 to 4.
  - A positive value N makes the write port 2^N times wider and 2^N times shallower than the read port.
  - A negative value makes the write port narrower by the same rule.
  - Read width times read depth equals write width times write depth.
  - Example: a 16-bit, 16-deep write port with exponent -2 gives a 64-bit read port with 4 words and a 2-bit read address.
- R2: Wide word i covers narrow words i*R through i*R+R-1. R is 2^|exponent|. Narrow word i*R+j sits in bits [j*NW +: NW] of wide word i, where NW is the narrow width, so the lowest narrow address is in the least significant bits.
- R3: With byte enables turned on, write-enable bit k gates write-data bits [8k+7:8k]. Bytes whose enable is 0 keep their stored value. The enable input is write width / 8 bits wide, or 1 bit when the write width is below 8.
- R4: While the write enable is low, a clock edge leaves the memory contents unchanged.
- R5: Write address stall.
  - When the write address enable is high, the write uses the address on the write-address input and captures it.
  - When it is low, the write goes to the last captured write address.
- R6: Read address stall.
  - When the read address enable is high, the read uses the read-address input and captures it.
  - When it is low, the read uses the last captured read address.
  - Capture happens on every edge where the enable is high, whether or not the read enable is high.
- R7: While the read enable is low, the read data output holds its value, even if the memory or the address changes.
- R8: A high reset at a read-clock edge clears the read data output to zero on that edge. This takes priority over the read enable.
- R9: Read data for an address appears on the output right after the clock edge that reads that address. The latency is one edge.
- R10: In single-clock mode, a read and a write to the same location on the same edge return the contents from before the write.
- R11: With the dual-clock parameter at 0, both ports run on the write clock and the read-clock input has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock. Also the read clock in single-clock mode. |
| rd_clk | input | 1 | Read clock, used only in dual-clock mode. |
| rst | input | 1 | Synchronous active-high clear of the read data and read address registers. |
| wr_en | input | 1 | Write strobe. |
| wr_addr_en | input | 1 | Enable to capture a new write address. |
| wr_addr | input | WR_AW | Write address, in write-port words. |
| wr_data | input | WR_WIDTH | Write data. |
| wr_be | input | BE_W | Byte-group write enables. |
| rd_en | input | 1 | Enable to load the read data register. |
| rd_addr_en | input | 1 | Enable to capture a new read address. |
| rd_addr | input | RD_AW | Read address, in read-port words. |
| rd_data | output | RD_WIDTH | Registered read data. |

## Verification
The bench uses a narrow write port (16 bits) and a wide read port (64 bits). It fills every narrow word with a distinct value, then reads every wide word. If the lane order were reversed or the row/lane split were wrong, narrow words would show up in the wrong slices.

Partial byte masks, including an all-zero mask, are applied to single words. A design that ignored the mask would overwrite bytes that should have been kept.

Stalled addresses are exercised together with writes that land under them. This shows a stalled read really re-reads the held location rather than just freezing its output. It also shows a stalled write goes to the captured address, not to the one on the pins.

A same-edge write and read to one wide word must return the old word. A reset during a read must clear the output even with the read enable high. A read with the enable low must not move the output.

// File: rtl/asym_ram_pkg.sv
package asym_ram_pkg;

    typedef enum logic [1:0] {
        SIDE_EQUAL   = 2'd0,
        SIDE_WR_WIDE = 2'd1,
        SIDE_RD_WIDE = 2'd2
    } width_side_e;

    function automatic int abs_log(input int lg);
        return (lg < 0) ? -lg : lg;
    endfunction

    function automatic int rd_width_of(input int wr_w, input int lg);
        return (lg >= 0) ? (wr_w >> lg) : (wr_w << (-lg));
    endfunction

    function automatic int rd_depth_of(input int wr_d, input int lg);
        return (lg >= 0) ? (wr_d << lg) : (wr_d >> (-lg));
    endfunction

    function automatic int addr_bits(input int depth);
        return (depth <= 2) ? 1 : $clog2(depth);
    endfunction

    function automatic int min_of(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

    function automatic width_side_e side_of(input int lg);
        if (lg > 0)
            return SIDE_WR_WIDE;
        else if (lg < 0)
            return SIDE_RD_WIDE;
        else
            return SIDE_EQUAL;
    endfunction

endpackage

// File: rtl/asym_ram_addr_hold.sv
module asym_ram_addr_hold #(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cap,
    input  logic [AW-1:0] addr_in,
    output logic [AW-1:0] addr_eff,
    output logic [AW-1:0] addr_q
);

    // Effective address: the live input while capturing, else the held one.
    assign addr_eff = cap ? addr_in : addr_q;

    always_ff @(posedge clk) begin
        if (rst)
            addr_q <= '0;
        else
            addr_q <= addr_eff;
    end

endmodule

// File: rtl/asym_ram_lane_bank.sv
module asym_ram_lane_bank #(
    parameter int W     = 16,
    parameter int DEPTH = 8,
    parameter int AW    = 3
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] wrow,
    input  logic [W-1:0]  wdata,
    input  logic [W-1:0]  wmask,
    input  logic [AW-1:0] rrow,
    output logic [W-1:0]  rdata
);

    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            mem[wrow] <= (mem[wrow] & ~wmask) | (wdata & wmask);
    end

    assign rdata = mem[rrow];

endmodule

// File: rtl/asym_ram_rd_reg.sv
module asym_ram_rd_reg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (en)
            q <= d;
    end

endmodule

// File: rtl/asym_sdp_ram.sv
module asym_sdp_ram
    import asym_ram_pkg::*;
#(
    parameter int WR_WIDTH   = 16,
    parameter int WR_DEPTH   = 8,
    parameter int RATIO_LOG2 = 0,
    parameter bit BYTE_EN    = 1'b0,
    parameter bit DUAL_CLK   = 1'b0,
    localparam int RD_WIDTH  = rd_width_of(WR_WIDTH, RATIO_LOG2),
    localparam int RD_DEPTH  = rd_depth_of(WR_DEPTH, RATIO_LOG2),
    localparam int WR_AW     = addr_bits(WR_DEPTH),
    localparam int RD_AW     = addr_bits(RD_DEPTH),
    localparam int BE_W      = (WR_WIDTH >= 8) ? (WR_WIDTH / 8) : 1
) (
    input  logic                wr_clk,
    input  logic                rd_clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic                wr_addr_en,
    input  logic [WR_AW-1:0]    wr_addr,
    input  logic [WR_WIDTH-1:0] wr_data,
    input  logic [BE_W-1:0]     wr_be,
    input  logic                rd_en,
    input  logic                rd_addr_en,
    input  logic [RD_AW-1:0]    rd_addr,
    output logic [RD_WIDTH-1:0] rd_data
);

    localparam int          LOG_R  = abs_log(RATIO_LOG2);
    localparam int          R      = 1 << LOG_R;
    localparam int          NW     = min_of(WR_WIDTH, RD_WIDTH);
    localparam int          ROW_D  = min_of(WR_DEPTH, RD_DEPTH);
    localparam int          ROW_AW = addr_bits(ROW_D);
    localparam width_side_e SIDE   = side_of(RATIO_LOG2);

    typedef struct packed {
        logic              we;
        logic [ROW_AW-1:0] row;
        logic [NW-1:0]     data;
        logic [NW-1:0]     mask;
    } lane_wr_t;

    // Clock selection
    logic rd_clk_i;

    generate
        if (DUAL_CLK) begin : g_dual_clk
            assign rd_clk_i = rd_clk;
        end else begin : g_single_clk
            logic rd_clk_unused;
            assign rd_clk_unused = rd_clk;
            assign rd_clk_i      = wr_clk;
        end
    endgenerate

    // Address registers
    logic [WR_AW-1:0] wr_addr_eff;
    logic [WR_AW-1:0] wr_addr_q;
    logic [RD_AW-1:0] rd_addr_eff;
    logic [RD_AW-1:0] rd_addr_q;

    asym_ram_addr_hold #(.AW(WR_AW)) u_wr_hold (
        .clk      (wr_clk),
        .rst      (1'b0),
        .cap      (wr_addr_en),
        .addr_in  (wr_addr),
        .addr_eff (wr_addr_eff),
        .addr_q   (wr_addr_q)
    );

    asym_ram_addr_hold #(.AW(RD_AW)) u_rd_hold (
        .clk      (rd_clk_i),
        .rst      (rst),
        .cap      (rd_addr_en),
        .addr_in  (rd_addr),
        .addr_eff (rd_addr_eff),
        .addr_q   (rd_addr_q)
    );

    // Bit mask from byte-group enables
    logic [WR_WIDTH-1:0] wr_mask;

    generate
        if (BYTE_EN) begin : g_be_on
            for (genvar b = 0; b < WR_WIDTH; b++) begin : g_bit
                assign wr_mask[b] = wr_be[b / 8];
            end
        end else begin : g_be_off
            logic be_unused;
            assign be_unused = ^wr_be;
            assign wr_mask   = '1;
        end
    endgenerate

    // Read row selection and lane data
    logic [ROW_AW-1:0]   rd_row;
    logic [NW-1:0]       lane_rd [R];
    logic [RD_WIDTH-1:0] rd_next;
    logic [R-1:0]        bank_we_vec;

    generate
        if (SIDE == SIDE_WR_WIDE) begin : g_rd_narrow
            logic [LOG_R-1:0] rd_sel;
            assign rd_row  = ROW_AW'(rd_addr_eff >> LOG_R);
            assign rd_sel  = rd_addr_eff[LOG_R-1:0];
            assign rd_next = lane_rd[rd_sel];
        end else begin : g_rd_wide
            assign rd_row = ROW_AW'(rd_addr_eff);
            for (genvar j = 0; j < R; j++) begin : g_cat
                assign rd_next[j*NW +: NW] = lane_rd[j];
            end
        end
    endgenerate

    // Lanes
    generate
        for (genvar j = 0; j < R; j++) begin : g_lane
            lane_wr_t lw;

            if (SIDE == SIDE_RD_WIDE) begin : g_wr_narrow
                always_comb begin
                    lw.we   = wr_en && (wr_addr_eff[LOG_R-1:0] == LOG_R'(j));
                    lw.row  = ROW_AW'(wr_addr_eff >> LOG_R);
                    lw.data = wr_data;
                    lw.mask = wr_mask;
                end
            end else begin : g_wr_wide
                always_comb begin
                    lw.we   = wr_en;
                    lw.row  = ROW_AW'(wr_addr_eff);
                    lw.data = wr_data[j*NW +: NW];
                    lw.mask = wr_mask[j*NW +: NW];
                end
            end

            assign bank_we_vec[j] = lw.we;

            asym_ram_lane_bank #(
                .W     (NW),
                .DEPTH (ROW_D),
                .AW    (ROW_AW)
            ) u_bank (
                .clk   (wr_clk),
                .we    (lw.we),
                .wrow  (lw.row),
                .wdata (lw.data),
                .wmask (lw.mask),
                .rrow  (rd_row),
                .rdata (lane_rd[j])
            );
        end
    endgenerate

    // Output register
    asym_ram_rd_reg #(.W(RD_WIDTH)) u_rd_reg (
        .clk (rd_clk_i),
        .rst (rst),
        .en  (rd_en),
        .d   (rd_next),
        .q   (rd_data)
    );

endmodule

// File: rtl/asym_sdp_ram_chk.sv
module asym_sdp_ram_chk #(
    parameter int RD_WIDTH = 16,
    parameter int RD_AW    = 3,
    parameter int WR_AW    = 3,
    parameter int R        = 1
) (
    input logic                rclk,
    input logic                wclk,
    input logic                rst,
    input logic                rd_en,
    input logic                rd_addr_en,
    input logic                wr_en,
    input logic                wr_addr_en,
    input logic [RD_WIDTH-1:0] rd_data,
    input logic [RD_AW-1:0]    rd_addr_q,
    input logic [WR_AW-1:0]    wr_addr_q,
    input logic [R-1:0]        bank_we
);

    // R8
    rst_clears_out_chk: assert property (@(posedge rclk)
        rst |=> (rd_data == '0));

    // R7
    rd_en_hold_chk: assert property (@(posedge rclk) disable iff (rst)
        !rd_en |=> $stable(rd_data));

    // R6
    rd_addr_stall_chk: assert property (@(posedge rclk) disable iff (rst)
        !rd_addr_en |=> (rd_addr_q == $past(rd_addr_q)));

    // R5
    wr_addr_stall_chk: assert property (@(posedge wclk) disable iff (rst)
        !wr_addr_en |=> $stable(wr_addr_q));

    // R4
    no_write_strobe_chk: assert property (@(posedge wclk) disable iff (rst)
        !wr_en |-> (bank_we == '0));

endmodule

bind asym_sdp_ram asym_sdp_ram_chk #(
    .RD_WIDTH (RD_WIDTH),
    .RD_AW    (RD_AW),
    .WR_AW    (WR_AW),
    .R        (R)
) u_chk (
    .rclk       (rd_clk_i),
    .wclk       (wr_clk),
    .rst        (rst),
    .rd_en      (rd_en),
    .rd_addr_en (rd_addr_en),
    .wr_en      (wr_en),
    .wr_addr_en (wr_addr_en),
    .rd_data    (rd_data),
    .rd_addr_q  (rd_addr_q),
    .wr_addr_q  (wr_addr_q),
    .bank_we    (bank_we_vec)
);

// File: tb/asym_sdp_ram_bench.sv
`timescale 1ns/1ps
module asym_sdp_ram_bench;

    logic        clk        = 1'b0;
    logic        rd_clk     = 1'b0;
    logic        rst        = 1'b1;
    logic        wr_en      = 1'b0;
    logic        wr_addr_en = 1'b1;
    logic [3:0]  wr_addr    = '0;
    logic [15:0] wr_data    = '0;
    logic [1:0]  wr_be      = '0;
    logic        rd_en      = 1'b0;
    logic        rd_addr_en = 1'b1;
    logic [1:0]  rd_addr    = '0;
    logic [63:0] rd_data;

    int total = 0;
    int bad   = 0;

    logic [15:0] m [16];

    always #2.5 clk = ~clk;

    asym_sdp_ram #(
        .WR_WIDTH   (16),
        .WR_DEPTH   (16),
        .RATIO_LOG2 (-2),
        .BYTE_EN    (1'b1),
        .DUAL_CLK   (1'b0)
    ) u_asym_sdp_ram (
        .wr_clk     (clk),
        .rd_clk     (rd_clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_addr_en (wr_addr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .wr_be      (wr_be),
        .rd_en      (rd_en),
        .rd_addr_en (rd_addr_en),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data)
    );

    function automatic logic [63:0] exp_word(input int i);
        return {m[4*i+3], m[4*i+2], m[4*i+1], m[4*i]};
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [3:0] a, input logic [15:0] d, input logic [1:0] be,
                            input logic aen, input logic we);
        @(negedge clk);
        wr_en = we; wr_addr_en = aen; wr_addr = a; wr_data = d; wr_be = be;
        @(negedge clk);
        wr_en = 1'b0; wr_addr_en = 1'b0;
    endtask

    task automatic model_write(input logic [3:0] a, input logic [15:0] d, input logic [1:0] be);
        if (be[0]) m[a][7:0]  = d[7:0];
        if (be[1]) m[a][15:8] = d[15:8];
    endtask

    task automatic do_read(input logic [1:0] a, input logic aen, input logic en);
        @(negedge clk);
        rd_en = en; rd_addr_en = aen; rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0; rd_addr_en = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog act=hung exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [63:0] saved;
        logic [63:0] old;

        repeat (3) @(negedge clk);
        rst = 1'b0; wr_addr_en = 1'b0; rd_addr_en = 1'b0;
        // R8: reset state of the output
        check("R8 reset state", rd_data, 64'h0);
        // R1: derived read width and address width
        check("R1 read width", 64'($bits(rd_data)), 64'd64);
        check("R1 read addr width", 64'($bits(rd_addr)), 64'd2);

        // R2 / R9: fill every narrow word, read every wide word
        for (int n = 0; n < 16; n++) begin
            logic [15:0] d;
            d = 16'h3C00 + 16'(n) * 16'h0101 + 16'(n * 7);
            do_write(4'(n), d, 2'b11, 1'b1, 1'b1);
            model_write(4'(n), d, 2'b11);
        end
        for (int i = 0; i < 4; i++) begin
            do_read(2'(i), 1'b1, 1'b1);
            check($sformatf("R2 R9 lane order word %0d", i), rd_data, exp_word(i));
        end

        // R3: byte masks
        do_write(4'd5, 16'hFFFF, 2'b01, 1'b1, 1'b1); model_write(4'd5, 16'hFFFF, 2'b01);
        do_write(4'd6, 16'h0000, 2'b10, 1'b1, 1'b1); model_write(4'd6, 16'h0000, 2'b10);
        do_write(4'd7, 16'h1234, 2'b00, 1'b1, 1'b1); model_write(4'd7, 16'h1234, 2'b00);
        do_read(2'd1, 1'b1, 1'b1);
        check("R3 byte masks", rd_data, exp_word(1));

        // R4: write enable low leaves contents alone
        do_write(4'd0, 16'hDEAD, 2'b11, 1'b1, 1'b0);
        do_read(2'd0, 1'b1, 1'b1);
        check("R4 no write", rd_data, exp_word(0));

        // R5: stalled write address
        do_write(4'd9, 16'h1111, 2'b11, 1'b1, 1'b1); model_write(4'd9, 16'h1111, 2'b11);
        do_write(4'd2, 16'h2222, 2'b11, 1'b0, 1'b1); model_write(4'd9, 16'h2222, 2'b11);
        do_read(2'd2, 1'b1, 1'b1);
        check("R5 stalled write target", rd_data, exp_word(2));
        do_read(2'd0, 1'b1, 1'b1);
        check("R5 pin address untouched", rd_data, exp_word(0));

        // R6: stalled read address
        do_read(2'd3, 1'b1, 1'b1);
        check("R6 capture", rd_data, exp_word(3));
        do_read(2'd1, 1'b0, 1'b1);
        check("R6 stalled read", rd_data, exp_word(3));
        do_write(4'd13, 16'h7777, 2'b11, 1'b1, 1'b1); model_write(4'd13, 16'h7777, 2'b11);
        do_read(2'd0, 1'b0, 1'b1);
        check("R6 stalled reread", rd_data, exp_word(3));

        // R7: read enable low holds the output
        do_read(2'd0, 1'b1, 1'b1);
        saved = rd_data;
        check("R7 setup", rd_data, exp_word(0));
        do_write(4'd1, 16'hABCD, 2'b11, 1'b1, 1'b1); model_write(4'd1, 16'hABCD, 2'b11);
        do_read(2'd2, 1'b1, 1'b0);
        check("R7 hold", rd_data, saved);
        do_read(2'd1, 1'b0, 1'b1);
        check("R6 capture without read enable", rd_data, exp_word(2));

        // R10: same-edge write and read return old data
        old = exp_word(2);
        @(negedge clk);
        wr_en = 1'b1; wr_addr_en = 1'b1; wr_addr = 4'd10; wr_data = 16'hBEEF; wr_be = 2'b11;
        rd_en = 1'b1; rd_addr_en = 1'b1; rd_addr = 2'd2;
        @(negedge clk);
        wr_en = 1'b0; wr_addr_en = 1'b0; rd_en = 1'b0; rd_addr_en = 1'b0;
        check("R10 read first", rd_data, old);
        model_write(4'd10, 16'hBEEF, 2'b11);
        do_read(2'd2, 1'b1, 1'b1);
        check("R10 new value after", rd_data, exp_word(2));

        // R8: reset beats read enable
        @(negedge clk);
        rst = 1'b1; rd_en = 1'b1; rd_addr_en = 1'b1; rd_addr = 2'd3;
        @(negedge clk);
        rst = 1'b0; rd_en = 1'b0; rd_addr_en = 1'b0;
        check("R8 reset clears", rd_data, 64'h0);

        // R11: rd_clk held low the whole run; reads still follow wr_clk
        do_read(2'd1, 1'b1, 1'b1);
        check("R11 single clock read", rd_data, exp_word(1));

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule